// File: doc/BRIEF.md
# USB Bus Reset, Suspend and Remote Wakeup Watcher

This block sits beside a USB device transceiver and watches the decoded line state on every cycle of the 48 MHz core clock. It recognises a bus reset from a long single-ended-zero stretch, recognises suspend from a long idle (J) stretch, and tracks the device through Default, Address, Configured and a dedicated Suspended-from-Configured state. Firmware moves the device out of Default and Address by writing the device address and the configuration value. A bus reset clears only the address and the event status bits. The configuration value the firmware last wrote is kept.

When firmware asks for a remote wakeup while the device is suspended out of Configured, the block first makes sure the bus has been idle for the minimum pre-wakeup time. The idle counter keeps running through suspend detection, so a request that arrives right after suspend is held off for the remaining difference, and a late request starts almost at once. The block then asserts a K-drive output for a fixed time, returns the device to Configured and signals completion. Any line activity during the hold-off is taken as a host resume and cancels the request.

All timing comes from parameterised cycle counts. The defaults correspond to 48 MHz: 121 cycles of SE0 for reset, 3 ms for suspend, 5 ms pre-wakeup idle and 10 ms of K.

Top module: `usb_link_watch`

## Requirements
- R1: After synchronous reset `dev_state` is 0 (Default), `dev_addr`, `cfg_value` and `status` are 0, and `suspended`, `drive_k` and all event pulses are low.
- R2: `line_state` codes are 2'b00 SE0, 2'b01 J (idle), 2'b10 K, 2'b11 non-idle. If SE0 is presented for RESET_CYC consecutive cycles starting before clock edge n, `bus_reset_p` is high for one cycle after edge n+RESET_CYC. A stretch one cycle shorter gives no pulse, and a longer stretch gives only one. At most one of the four event pulses is high in any cycle.
- R3: A bus reset sets `dev_addr` and `status` to 0, `dev_state` to Default and `suspended` to 0, and leaves `cfg_value` unchanged.
- R4: If J is presented for SUSP_CYC consecutive cycles starting before edge n, then after edge n+SUSP_CYC `suspend_p` pulses, `suspended` is 1 and status bit 0 is set. Configured (2) becomes Suspended-from-Configured (3), and Default or Address stays as it is.
- R5: A non-J line value presented before edge n while suspended gives, after edge n+1, a `host_resume_p` pulse, `suspended` 0 and status bit 1 set, and state 3 returns to 2.
- R6: `wake_req` is honoured only in state 3. In any other state it has no effect: `drive_k` stays low and the state is unchanged.
- R7: If J has been presented since before edge n and `wake_req` is accepted at edge m, `drive_k` rises after edge max(n+IDLE_MIN_CYC+1, m+1).
- R8: `drive_k` stays high for exactly WAKE_K_CYC cycles and the line is ignored meanwhile. In the cycle after it falls, `resume_done_p` pulses, state is 2, `suspended` is 0 and status bit 2 is set.
- R9: Non-J activity while a wakeup is waiting cancels it as a host resume (R5), and `drive_k` never rises. If the request and the first activity are sampled on the same edge, the resume wins.
- R10: Writing a nonzero address in Default or Address stores it and enters Address (1), and writing zero returns to Default. Writing a nonzero `cfg_wdata` in Address stores it and enters Configured, and writing zero in Configured returns to Address. Address writes in Configured are ignored.
- R11: `status_clr` clears status bits write-one-to-clear. A set and a clear of the same bit on one edge leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (48 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 non-idle |
| addr_we | input | 1 | Device address write strobe |
| addr_wdata | input | 7 | Device address value |
| cfg_we | input | 1 | Configuration value write strobe |
| cfg_wdata | input | 8 | Configuration value |
| status_clr | input | 3 | Write-one-to-clear mask for status |
| wake_req | input | 1 | Firmware remote wakeup request |
| dev_state | output | 2 | 0 Default, 1 Address, 2 Configured, 3 Suspended-from-Configured |
| dev_addr | output | 7 | Current device address |
| cfg_value | output | 8 | Stored configuration value |
| status | output | 3 | Bit 0 suspend, bit 1 host resume, bit 2 wakeup done |
| suspended | output | 1 | Device is suspended |
| bus_reset_p | output | 1 | One-cycle bus reset event |
| suspend_p | output | 1 | One-cycle suspend event |
| host_resume_p | output | 1 | One-cycle host resume event |
| resume_done_p | output | 1 | One-cycle end-of-wakeup event |
| drive_k | output | 1 | Request to drive K on the bus |

## Verification
Two collisions matter here. A wakeup request can land on the same edge as the first sample of host activity, and a firmware status clear can land on the edge where a suspend sets the same bit. The bench places the K stimulus one cycle ahead of the request so that both are sampled together. It then expects a resume event with no K-drive rise. It also times the clear to the exact edge on which suspend fires and expects the bit to read as set. A scoreboard holds every expected event with its exact cycle, so any extra or missing pulse, including a stray K start, is reported.

// File: rtl/usb_lw_pkg.sv
package usb_lw_pkg;

  typedef enum logic [1:0] {
    DS_DEFAULT    = 2'd0,
    DS_ADDRESS    = 2'd1,
    DS_CONFIGURED = 2'd2,
    DS_SUSP_CFG   = 2'd3
  } dev_state_e;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_WAIT  = 2'd1,
    WK_DRIVE = 2'd2
  } wake_state_e;

  localparam logic [1:0] LN_SE0 = 2'b00;
  localparam logic [1:0] LN_J   = 2'b01;
  localparam logic [1:0] LN_K   = 2'b10;

  localparam int STAT_W   = 3;
  localparam int ST_SUSP  = 0;
  localparam int ST_HRES  = 1;
  localparam int ST_WDONE = 2;

endpackage

// File: rtl/usb_lw_run_cnt.sv
module usb_lw_run_cnt #(
  parameter int LIMIT = 4,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = W'(LIMIT);

  // counts consecutive cycles with run high, holds at LIMIT
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/usb_lw_line_timer.sv
module usb_lw_line_timer
  import usb_lw_pkg::*;
#(
  parameter int RESET_CYC    = 121,
  parameter int SUSP_CYC     = 144000,
  parameter int IDLE_MIN_CYC = 240000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_in,
  input  logic       tx_active,
  output logic       line_act,
  output logic       se0_hit,
  output logic       idle_hit,
  output logic       idle_ok
);

  localparam int SW = $clog2(RESET_CYC + 1);
  localparam int IW = $clog2(IDLE_MIN_CYC + 1);
  localparam logic [SW-1:0] SE0_LAST  = SW'(RESET_CYC - 1);
  localparam logic [IW-1:0] SUSP_LAST = IW'(SUSP_CYC - 1);
  localparam logic [IW-1:0] IDLE_FULL = IW'(IDLE_MIN_CYC);

  logic [1:0]    line_q;
  logic          is_j;
  logic          is_se0;
  logic [SW-1:0] se0_cnt;
  logic [IW-1:0] idle_cnt;

  // one register stage on the decoded line; reset value is non-idle
  always_ff @(posedge clk) begin
    if (rst) line_q <= LN_K;
    else     line_q <= line_in;
  end

  assign is_j   = (line_q == LN_J)   && !tx_active;
  assign is_se0 = (line_q == LN_SE0) && !tx_active;

  usb_lw_run_cnt #(.LIMIT(RESET_CYC), .W(SW)) u_se0_cnt (
    .clk (clk),
    .rst (rst),
    .run (is_se0),
    .cnt (se0_cnt)
  );

  usb_lw_run_cnt #(.LIMIT(IDLE_MIN_CYC), .W(IW)) u_idle_cnt (
    .clk (clk),
    .rst (rst),
    .run (is_j),
    .cnt (idle_cnt)
  );

  assign line_act = (line_q != LN_J) && !tx_active;
  assign se0_hit  = is_se0 && (se0_cnt == SE0_LAST);
  assign idle_hit = is_j && (idle_cnt == SUSP_LAST);
  assign idle_ok  = is_j && (idle_cnt == IDLE_FULL);

  // a reset hit is reported once per SE0 stretch
  assert_reset_once_R2: assert property (@(posedge clk) disable iff (rst)
    se0_hit |=> !se0_hit);

  // suspend fires once per idle stretch
  assert_suspend_once_R4: assert property (@(posedge clk) disable iff (rst)
    idle_hit |=> !idle_hit);

endmodule

// File: rtl/usb_lw_wake_seq.sv
module usb_lw_wake_seq
  import usb_lw_pkg::*;
#(
  parameter int WAKE_K_CYC = 480000
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_req,
  input  logic in_susp_cfg,
  input  logic line_act,
  input  logic idle_ok,
  output logic drive_k,
  output logic wake_done
);

  localparam int KW = $clog2(WAKE_K_CYC);
  localparam logic [KW-1:0] K_LAST = KW'(WAKE_K_CYC - 1);

  wake_state_e   st_q;
  logic [KW-1:0] k_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WK_IDLE;
      k_cnt <= '0;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (wake_req && in_susp_cfg && !line_act) st_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (line_act || !in_susp_cfg) begin
            st_q <= WK_IDLE;
          end else if (idle_ok) begin
            st_q  <= WK_DRIVE;
            k_cnt <= '0;
          end
        end
        WK_DRIVE: begin
          if (k_cnt == K_LAST) st_q  <= WK_IDLE;
          else                 k_cnt <= k_cnt + 1'b1;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign drive_k   = (st_q == WK_DRIVE);
  assign wake_done = (st_q == WK_DRIVE) && (k_cnt == K_LAST);

  // each K burst starts from a fresh length count
  assert_k_start_clean_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_k) |-> (k_cnt == '0));

  // activity during the hold-off drops the request
  assert_wait_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == WK_WAIT && line_act) |=> (st_q == WK_IDLE));

endmodule

// File: rtl/usb_lw_dev_fsm.sv
module usb_lw_dev_fsm
  import usb_lw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              se0_hit,
  input  logic              idle_hit,
  input  logic              line_act,
  input  logic              wake_done,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [STAT_W-1:0] status_clr,
  output logic [1:0]        dev_state,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [CFG_W-1:0]  cfg_value,
  output logic [STAT_W-1:0] status,
  output logic              suspended,
  output logic              bus_reset_p,
  output logic              suspend_p,
  output logic              host_resume_p,
  output logic              resume_done_p
);

  dev_state_e        st_q;
  logic [STAT_W-1:0] st_set;
  logic              go_susp;
  logic              go_resume;

  assign go_susp   = idle_hit && !suspended;
  assign go_resume = line_act && suspended;

  assign st_set[ST_SUSP]  = go_susp;
  assign st_set[ST_HRES]  = go_resume;
  assign st_set[ST_WDONE] = wake_done;

  assign dev_state = st_q;

  // status bits: bus reset clears, set beats a same-cycle clear
  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst || se0_hit) status[b] <= 1'b0;
      else                status[b] <= st_set[b] | (status[b] & ~status_clr[b]);
    end
  end

  // configuration value survives bus reset
  always_ff @(posedge clk) begin
    if (rst)         cfg_value <= '0;
    else if (cfg_we) cfg_value <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= DS_DEFAULT;
      dev_addr      <= '0;
      suspended     <= 1'b0;
      bus_reset_p   <= 1'b0;
      suspend_p     <= 1'b0;
      host_resume_p <= 1'b0;
      resume_done_p <= 1'b0;
    end else begin
      bus_reset_p   <= se0_hit;
      suspend_p     <= go_susp;
      host_resume_p <= go_resume;
      resume_done_p <= wake_done;
      if (se0_hit) begin
        st_q      <= DS_DEFAULT;
        dev_addr  <= '0;
        suspended <= 1'b0;
      end else if (wake_done) begin
        st_q      <= DS_CONFIGURED;
        suspended <= 1'b0;
      end else if (go_resume) begin
        suspended <= 1'b0;
        if (st_q == DS_SUSP_CFG) st_q <= DS_CONFIGURED;
      end else if (go_susp) begin
        suspended <= 1'b1;
        if (st_q == DS_CONFIGURED) st_q <= DS_SUSP_CFG;
      end else if (!suspended) begin
        if (addr_we && (st_q == DS_DEFAULT || st_q == DS_ADDRESS)) begin
          dev_addr <= addr_wdata;
          st_q     <= (addr_wdata != '0) ? DS_ADDRESS : DS_DEFAULT;
        end else if (cfg_we) begin
          if (st_q == DS_ADDRESS && cfg_wdata != '0)         st_q <= DS_CONFIGURED;
          else if (st_q == DS_CONFIGURED && cfg_wdata == '0) st_q <= DS_ADDRESS;
        end
      end
    end
  end

  assert_reset_clears_R3: assert property (@(posedge clk) disable iff (rst)
    bus_reset_p |-> (dev_addr == '0 && status == '0 &&
                     st_q == DS_DEFAULT && !suspended));

  assert_cfg_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_p && !$past(cfg_we)) |-> $stable(cfg_value));

  assert_suspend_enter_R4: assert property (@(posedge clk) disable iff (rst)
    suspend_p |-> (suspended && status[ST_SUSP]));

  assert_susp_cfg_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == DS_SUSP_CFG) |-> suspended);

  assert_resume_exit_R5: assert property (@(posedge clk) disable iff (rst)
    host_resume_p |-> (!suspended && status[ST_HRES] && st_q != DS_SUSP_CFG));

endmodule

// File: rtl/usb_link_watch.sv
module usb_link_watch
  import usb_lw_pkg::*;
#(
  parameter int RESET_CYC    = 121,
  parameter int SUSP_CYC     = 144000,
  parameter int IDLE_MIN_CYC = 240000,
  parameter int WAKE_K_CYC   = 480000,
  parameter int ADDR_W       = 7,
  parameter int CFG_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        line_state,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [STAT_W-1:0] status_clr,
  input  logic              wake_req,
  output logic [1:0]        dev_state,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [CFG_W-1:0]  cfg_value,
  output logic [STAT_W-1:0] status,
  output logic              suspended,
  output logic              bus_reset_p,
  output logic              suspend_p,
  output logic              host_resume_p,
  output logic              resume_done_p,
  output logic              drive_k
);

  logic line_act;
  logic se0_hit;
  logic idle_hit;
  logic idle_ok;
  logic wake_done;
  logic in_susp_cfg;

  assign in_susp_cfg = (dev_state == DS_SUSP_CFG);

  usb_lw_line_timer #(
    .RESET_CYC    (RESET_CYC),
    .SUSP_CYC     (SUSP_CYC),
    .IDLE_MIN_CYC (IDLE_MIN_CYC)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_state),
    .tx_active (drive_k),
    .line_act  (line_act),
    .se0_hit   (se0_hit),
    .idle_hit  (idle_hit),
    .idle_ok   (idle_ok)
  );

  usb_lw_wake_seq #(.WAKE_K_CYC(WAKE_K_CYC)) u_wake (
    .clk         (clk),
    .rst         (rst),
    .wake_req    (wake_req),
    .in_susp_cfg (in_susp_cfg),
    .line_act    (line_act),
    .idle_ok     (idle_ok),
    .drive_k     (drive_k),
    .wake_done   (wake_done)
  );

  usb_lw_dev_fsm #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .se0_hit       (se0_hit),
    .idle_hit      (idle_hit),
    .line_act      (line_act),
    .wake_done     (wake_done),
    .addr_we       (addr_we),
    .addr_wdata    (addr_wdata),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .status_clr    (status_clr),
    .dev_state     (dev_state),
    .dev_addr      (dev_addr),
    .cfg_value     (cfg_value),
    .status        (status),
    .suspended     (suspended),
    .bus_reset_p   (bus_reset_p),
    .suspend_p     (suspend_p),
    .host_resume_p (host_resume_p),
    .resume_done_p (resume_done_p)
  );

  assert_k_after_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_k) |-> $past(idle_ok));

  assert_k_in_susp_R6: assert property (@(posedge clk) disable iff (rst)
    drive_k |-> (dev_state == DS_SUSP_CFG));

  assert_done_after_k_R8: assert property (@(posedge clk) disable iff (rst)
    resume_done_p |-> ($past(drive_k) && !drive_k));

  assert_events_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_reset_p, suspend_p, host_resume_p, resume_done_p}));

endmodule

// File: tb/tb_usb_link_watch.sv
`timescale 1ns/1ps
module tb_usb_link_watch;

  localparam int R = 6;
  localparam int S = 20;
  localparam int I = 34;
  localparam int K = 12;

  localparam logic [1:0] SE0 = 2'b00;
  localparam logic [1:0] LJ  = 2'b01;
  localparam logic [1:0] LK  = 2'b10;

  localparam int EV_RST = 0, EV_SUSP = 1, EV_HRES = 2, EV_KST = 3, EV_DONE = 4;

  typedef struct { int kind; int stamp; } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] line_state = LK;
  logic       addr_we = 1'b0;
  logic [6:0] addr_wdata = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] status_clr = '0;
  logic       wake_req = 1'b0;
  logic [1:0] dev_state;
  logic [6:0] dev_addr;
  logic [7:0] cfg_value;
  logic [2:0] status;
  logic       suspended, bus_reset_p, suspend_p, host_resume_p, resume_done_p, drive_k;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  k_prev = 1'b0;
  bit  done_flag = 1'b0;
  ev_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_link_watch #(
    .RESET_CYC(R), .SUSP_CYC(S), .IDLE_MIN_CYC(I), .WAKE_K_CYC(K)
  ) dut (
    .clk(clk), .rst(rst), .line_state(line_state),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .status_clr(status_clr), .wake_req(wake_req),
    .dev_state(dev_state), .dev_addr(dev_addr), .cfg_value(cfg_value),
    .status(status), .suspended(suspended), .bus_reset_p(bus_reset_p),
    .suspend_p(suspend_p), .host_resume_p(host_resume_p),
    .resume_done_p(resume_done_p), .drive_k(drive_k)
  );

  function automatic string req_of(int k);
    case (k)
      EV_RST:  return "R2";
      EV_SUSP: return "R4";
      EV_HRES: return "R5";
      EV_KST:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(int k, int t);
    ev_t e;
    e.kind = k;
    e.stamp = t;
    exp_q.push_back(e);
  endtask

  task automatic see_ev(int k);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event: actual kind %0d at %0d, expected none", req_of(k), k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.stamp != cyc) begin
        errors++;
        $display("FAIL %s event: actual kind %0d at %0d, expected kind %0d at %0d",
                 req_of(e.kind), k, cyc, e.kind, e.stamp);
      end
    end
  endtask

  // monitor: pops the scoreboard as events appear
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_reset_p)        see_ev(EV_RST);
      if (suspend_p)          see_ev(EV_SUSP);
      if (host_resume_p)      see_ev(EV_HRES);
      if (drive_k && !k_prev) see_ev(EV_KST);
      if (resume_done_p)      see_ev(EV_DONE);
    end
    k_prev = drive_k;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int n;
    int c;
    int d;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(dev_state == 2'd0, "R1", "dev_state", dev_state, 0);
    chk(dev_addr == 0 && cfg_value == 0, "R1", "addr|cfg", {dev_addr, cfg_value}, 0);
    chk(status == 0 && !suspended && !drive_k, "R1", "status/flags", {status, suspended, drive_k}, 0);

    // R10 firmware writes
    addr_we = 1'b1; addr_wdata = 7'd5; step(1); addr_we = 1'b0;
    chk(dev_state == 2'd1, "R10", "state after address", dev_state, 1);
    chk(dev_addr == 7'd5, "R10", "address", dev_addr, 5);
    cfg_we = 1'b1; cfg_wdata = 8'd3; step(1); cfg_we = 1'b0;
    chk(dev_state == 2'd2, "R10", "state after config", dev_state, 2);
    addr_we = 1'b1; addr_wdata = 7'd9; step(1); addr_we = 1'b0;
    chk(dev_addr == 7'd5, "R10", "address write in configured ignored", dev_addr, 5);

    // R6 wake request while configured, not suspended
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    step(I + K + 4);
    chk(dev_state == 2'd2 && !drive_k, "R6", "state after ignored wake", dev_state, 2);

    // R4 suspend from configured
    line_state = LJ; n = cyc + 1;
    expect_ev(EV_SUSP, n + S);
    wait_until(n + S + 2);
    chk(dev_state == 2'd3, "R4", "suspended state", dev_state, 3);
    chk(suspended && status == 3'b001, "R4", "suspend status", status, 1);

    // R5 host resume
    line_state = LK; c = cyc;
    expect_ev(EV_HRES, c + 2);
    wait_until(c + 3);
    chk(dev_state == 2'd2 && !suspended, "R5", "state after resume", dev_state, 2);
    chk(status == 3'b011, "R5", "resume status", status, 3);

    // R11 write-one-to-clear
    status_clr = 3'b001; step(1); status_clr = 3'b000;
    chk(status == 3'b010, "R11", "status after clear", status, 2);

    // R7 and R8: wakeup requested right after suspend, extra idle inserted
    line_state = LJ; n = cyc + 1;
    expect_ev(EV_SUSP, n + S);
    wait_until(n + S);
    wake_req = 1'b1;
    expect_ev(EV_KST, n + I + 1);
    expect_ev(EV_DONE, n + I + 1 + K);
    step(1); wake_req = 1'b0;
    d = n + I + 1 + K;
    wait_until(d - 1);
    chk(drive_k == 1'b1, "R8", "K still driven in last cycle", drive_k, 1);
    step(1);
    chk(dev_state == 2'd2 && !suspended && !drive_k, "R8", "state after wakeup", dev_state, 2);
    chk(status == 3'b111, "R8", "wakeup status", status, 7);
    // idle restarts after K, device suspends again
    expect_ev(EV_SUSP, d + S);

    // R7 late request: K starts one edge after acceptance
    wait_until(d + S + I + 2);
    c = cyc;
    wake_req = 1'b1;
    expect_ev(EV_KST, c + 2);
    expect_ev(EV_DONE, c + 2 + K);
    step(1); wake_req = 1'b0;
    wait_until(c + 2 + K);
    line_state = LK;
    step(1);
    chk(dev_state == 2'd2, "R7", "state after late wakeup", dev_state, 2);

    // R9 activity during hold-off cancels the wakeup
    line_state = LJ; n = cyc + 1;
    expect_ev(EV_SUSP, n + S);
    wait_until(n + S);
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    wait_until(n + S + 3);
    line_state = LK;
    expect_ev(EV_HRES, n + S + 5);
    wait_until(n + I + K + 4);
    chk(dev_state == 2'd2 && !drive_k, "R9", "state after cancelled wake", dev_state, 2);

    // R9 request and first activity sampled on one edge: resume wins
    line_state = LJ; n = cyc + 1;
    expect_ev(EV_SUSP, n + S);
    wait_until(n + S + 2);
    line_state = LK;
    expect_ev(EV_HRES, n + S + 4);
    step(1);
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    wait_until(n + I + K + 4);
    chk(dev_state == 2'd2 && !suspended, "R9", "state after same-edge collision", dev_state, 2);

    // R11 set and clear of the suspend bit on the same edge
    status_clr = 3'b111; step(1); status_clr = 3'b000;
    chk(status == 3'b000, "R11", "status cleared", status, 0);
    line_state = LJ; n = cyc + 1;
    expect_ev(EV_SUSP, n + S);
    wait_until(n + S - 1);
    status_clr = 3'b001; step(1); status_clr = 3'b000;
    chk(status[0] == 1'b1, "R11", "set wins over clear", status[0], 1);
    line_state = LK; c = cyc;
    expect_ev(EV_HRES, c + 2);
    wait_until(c + 3);

    // R2 short SE0 stretch gives no reset
    line_state = SE0; step(R - 1); line_state = LK; step(4);
    chk(dev_addr == 7'd5, "R2", "address after short SE0", dev_addr, 5);

    // R2 and R3 bus reset
    line_state = SE0; c = cyc;
    expect_ev(EV_RST, c + 1 + R);
    step(R + 5);
    line_state = LK;
    step(1);
    chk(dev_state == 2'd0 && !suspended, "R3", "state after bus reset", dev_state, 0);
    chk(dev_addr == 0, "R3", "address after bus reset", dev_addr, 0);
    chk(status == 0, "R3", "status after bus reset", status, 0);
    chk(cfg_value == 8'd3, "R3", "config kept", cfg_value, 3);

    // R4 and R6 suspend in Default, wake request ignored
    line_state = LJ; n = cyc + 1;
    expect_ev(EV_SUSP, n + S);
    wait_until(n + S + 1);
    chk(dev_state == 2'd0 && suspended, "R4", "default suspend keeps state", dev_state, 0);
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    step(I + K + 4);
    chk(dev_state == 2'd0 && !drive_k && suspended, "R6", "wake ignored in default", dev_state, 0);
    line_state = LK; c = cyc;
    expect_ev(EV_HRES, c + 2);
    wait_until(c + 3);
    chk(!suspended && dev_state == 2'd0, "R5", "resume from default suspend", suspended, 0);

    step(5);
    chk(exp_q.size() == 0, "R2", "events left in scoreboard", exp_q.size(), 0);
    done_flag = 1'b1;
    finish_run();
  end

endmodule